// File: doc/BRIEF.md
# Single-Precision Result Rounder

This block takes an intermediate floating-point result and turns it into a packed 32-bit IEEE-754 single-precision word. The intermediate value comes in as a sign, an unbiased signed exponent with more range than the packed format, and a normalized 24-bit significand with its leading one present, plus one guard bit and one sticky bit. The block rounds that value once, renormalizes by one bit if the increment carries out, detects overflow and flushes results that fall below the normal range. The producer upstream (adder, multiplier or fused multiply-add datapath) must not round its own result first, so that a fused operation is rounded only once.

Two rounding behaviours exist. Mode code 00 picks the nearest representable value and settles an exact tie toward the even significand. Any other code truncates toward zero. The three reserved codes all behave like truncation. When an overflow occurs in nearest mode the result is a signed infinity. When it occurs in truncation mode the result is the signed largest finite value. Two flags come out with each result: overflow, and inexact.

The operand enters over a valid/ready handshake and the result leaves over another, with one register stage between them. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. The stage is free (`in_ready` high) when it is empty or when its result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its flags hold still and no new operand is taken. `in_mode` is sampled together with the operand.

Top module: `fp_round_unit`

## Requirements
- R1: With `in_mode` = 00, the stored fraction is incremented exactly when the guard bit is 1 and either the sticky bit or the significand LSB is 1. An exact half with an even LSB is left as is, and an exact half with an odd LSB rounds up.
- R2: With `in_mode` = 01, guard and sticky are discarded and the 23 fraction bits are the significand's lower 23 bits unchanged.
- R3: Codes 10 and 11 give the same results and flags as code 01, and an operand accepted under any non-zero code never yields an exponent field of all ones.
- R4: If the nearest-mode increment carries out of the 24-bit significand, the fraction field becomes zero and the biased exponent goes up by one, before the overflow test.
- R5: In nearest mode, a value whose biased exponent after rounding reaches 255 (any value at or above 2^127·(2−2^−24)) gives 0x7F800000 with the input sign in bit 31, and raises overflow. 2^127·(2−2^−23) itself stays finite as 0x7F7FFFFF.
- R6: In truncation modes, a value whose biased exponent (unbiased + 127) is 255 or more gives 0x7F7FFFFF with the input sign in bit 31, and raises overflow. An overflow result is always one of these two magnitudes.
- R7: A non-zero operand whose biased exponent is 0 or less, tested before rounding, gives a signed zero with inexact = 1 and overflow = 0. The output never holds a subnormal pattern (exponent field 0 with a non-zero fraction). Biased exponent 1 packs normally.
- R8: Inexact equals guard OR sticky for finite normal results, and is 1 on every overflow. Overflow is 0 for every result that is not an overflow.
- R9: An all-zero significand gives a signed zero (bit 31 = sign, other bits 0), with inexact = guard OR sticky and overflow = 0.
- R10: A result appears one cycle after its operand is accepted. It holds stable while `out_ready` is low, and during that time `in_ready` stays low. Draining a result and accepting a new operand can happen on the same edge.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can take an operand this cycle |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 24 | Significand, leading one at bit 23 (all zero for a zero value) |
| in_guard | input | 1 | First bit below the significand LSB |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| in_mode | input | 2 | Rounding code: 00 nearest-even, others toward zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision result |
| out_overflow | output | 1 | Result overflowed the finite range |
| out_inexact | output | 1 | Result differs from the exact value |

## Verification
Two things can land in the same cycle. The first is the one-bit renormalization after a carry out of the significand. The second is the overflow decision. They meet when an all-ones significand at exponent 127 is rounded up. The bench drives that pattern directly in both modes and with both signs, and also with the guard bit clear just below the threshold. It expects infinity only in nearest mode with the carry taken, and the largest finite value everywhere else.

On the stream side, draining a held result and accepting a new operand also share one edge. The bench sets this up by stalling the output with a second operand already waiting. It then raises `out_ready` and checks that the old word held through the stall and that the new word follows on the very next cycle.

// File: rtl/fp_rnd_pkg.sv
package fp_rnd_pkg;

  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_WORD_W = 1 + SP_EXP_W + SP_FRAC_W;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TRUNC     = 2'b01,
    RND_SPARE_A   = 2'b10,
    RND_SPARE_B   = 2'b11
  } rnd_code_e;

  typedef struct packed {
    logic                 overflow;
    logic                 inexact;
    logic [SP_WORD_W-1:0] word;
  } rnd_result_t;

  function automatic logic uses_nearest(input logic [1:0] code);
    return code == RND_NEAR_EVEN;
  endfunction

endpackage

// File: rtl/fp_rnd_range.sv
module fp_rnd_range #(
  parameter int EXP_IN_W = 10,
  parameter int EXP_W    = fp_rnd_pkg::SP_EXP_W,
  parameter int SIG_W    = fp_rnd_pkg::SP_FRAC_W + 1,
  parameter int BEXP_W   = EXP_IN_W + 2
) (
  input  logic signed [EXP_IN_W-1:0] exp_unb,
  input  logic        [SIG_W-1:0]    sig,
  output logic signed [BEXP_W-1:0]   exp_biased,
  output logic                       is_zero,
  output logic                       is_tiny
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [BEXP_W-1:0] BIAS_S = BEXP_W'(BIAS);
  localparam logic signed [BEXP_W-1:0] MIN_NORMAL_S = BEXP_W'(1);

  logic signed [BEXP_W-1:0] exp_wide;

  always_comb begin
    exp_wide   = BEXP_W'(exp_unb);
    exp_biased = exp_wide + BIAS_S;
    is_zero    = ~|sig;
    is_tiny    = exp_biased < MIN_NORMAL_S;
  end

endmodule

// File: rtl/fp_rnd_incr.sv
module fp_rnd_incr #(
  parameter int FRAC_W = fp_rnd_pkg::SP_FRAC_W,
  parameter int SIG_W  = FRAC_W + 1
) (
  input  logic [SIG_W-1:0]  sig,
  input  logic              guard,
  input  logic              sticky,
  input  logic              nearest,
  output logic [FRAC_W-1:0] frac_out,
  output logic              carry,
  output logic              lossy
);

  logic             bump;
  logic [SIG_W:0]   sum;

  always_comb begin
    lossy = guard | sticky;
    bump  = nearest & guard & (sticky | sig[0]);
    sum   = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
    carry = sum[SIG_W];
  end

  generate
    if (SIG_W > 1) begin : g_renorm
      always_comb begin
        if (carry) frac_out = sum[SIG_W-1:1];
        else       frac_out = sum[FRAC_W-1:0];
      end
    end else begin : g_trivial
      always_comb frac_out = '0;
    end
  endgenerate

endmodule

// File: rtl/fp_rnd_pack.sv
module fp_rnd_pack
  import fp_rnd_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W,
  parameter int BEXP_W = 12,
  parameter int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic                     sign,
  input  logic signed [BEXP_W-1:0] exp_biased,
  input  logic                     carry,
  input  logic [FRAC_W-1:0]        frac,
  input  logic                     nearest,
  input  logic                     is_zero,
  input  logic                     is_tiny,
  input  logic                     lossy,
  output logic [WORD_W-1:0]        word,
  output logic                     overflow,
  output logic                     inexact
);

  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam logic signed [BEXP_W-1:0] EXP_TOP_S = BEXP_W'(EXP_TOP);
  localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0]  EXP_MAXF = EXP_ONES - 1'b1;

  logic signed [BEXP_W-1:0] exp_final;
  logic                     too_big;

  always_comb begin
    exp_final = exp_biased + $signed({{(BEXP_W-1){1'b0}}, carry});
    too_big   = exp_final >= EXP_TOP_S;
    word      = '0;
    overflow  = 1'b0;
    inexact   = lossy;
    if (is_zero) begin
      word = {sign, {(WORD_W-1){1'b0}}};
    end else if (is_tiny) begin
      word    = {sign, {(WORD_W-1){1'b0}}};
      inexact = 1'b1;
    end else if (too_big) begin
      overflow = 1'b1;
      inexact  = 1'b1;
      if (nearest) word = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      else         word = {sign, EXP_MAXF, {FRAC_W{1'b1}}};
    end else begin
      word = {sign, exp_final[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_rnd_pkg::*;
#(
  parameter int EXP_IN_W = 10,
  parameter int EXP_W    = SP_EXP_W,
  parameter int FRAC_W   = SP_FRAC_W,
  parameter bit REG_OUT  = 1'b1,
  localparam int SIG_W   = FRAC_W + 1,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W,
  localparam int BEXP_W  = EXP_IN_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sign,
  input  logic [EXP_IN_W-1:0] in_exp,
  input  logic [SIG_W-1:0]    in_sig,
  input  logic                in_guard,
  input  logic                in_sticky,
  input  logic [1:0]          in_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_overflow,
  output logic                out_inexact
);

  logic signed [BEXP_W-1:0] exp_biased;
  logic                     is_zero;
  logic                     is_tiny;
  logic [FRAC_W-1:0]        frac_rnd;
  logic                     carry;
  logic                     lossy;
  logic                     nearest;
  logic [WORD_W-1:0]        word_c;
  logic                     ovf_c;
  logic                     inx_c;

  assign nearest = uses_nearest(in_mode);

  fp_rnd_range #(
    .EXP_IN_W (EXP_IN_W),
    .EXP_W    (EXP_W),
    .SIG_W    (SIG_W),
    .BEXP_W   (BEXP_W)
  ) u_range (
    .exp_unb    ($signed(in_exp)),
    .sig        (in_sig),
    .exp_biased (exp_biased),
    .is_zero    (is_zero),
    .is_tiny    (is_tiny)
  );

  fp_rnd_incr #(
    .FRAC_W (FRAC_W),
    .SIG_W  (SIG_W)
  ) u_incr (
    .sig      (in_sig),
    .guard    (in_guard),
    .sticky   (in_sticky),
    .nearest  (nearest),
    .frac_out (frac_rnd),
    .carry    (carry),
    .lossy    (lossy)
  );

  fp_rnd_pack #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .BEXP_W (BEXP_W),
    .WORD_W (WORD_W)
  ) u_pack (
    .sign       (in_sign),
    .exp_biased (exp_biased),
    .carry      (carry),
    .frac       (frac_rnd),
    .nearest    (nearest),
    .is_zero    (is_zero),
    .is_tiny    (is_tiny),
    .lossy      (lossy),
    .word       (word_c),
    .overflow   (ovf_c),
    .inexact    (inx_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic [WORD_W-1:0] word_q;
      logic              ovf_q;
      logic              inx_q;

      assign in_ready = ~vld_q | out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          word_q <= '0;
          ovf_q  <= 1'b0;
          inx_q  <= 1'b0;
        end else begin
          if (in_ready) vld_q <= in_valid;
          if (in_ready && in_valid) begin
            word_q <= word_c;
            ovf_q  <= ovf_c;
            inx_q  <= inx_c;
          end
        end
      end

      assign out_valid    = vld_q;
      assign out_word     = word_q;
      assign out_overflow = ovf_q;
      assign out_inexact  = inx_q;
    end else begin : g_comb
      assign in_ready     = out_ready;
      assign out_valid    = in_valid;
      assign out_word     = word_c;
      assign out_overflow = ovf_c;
      assign out_inexact  = inx_c;
    end
  endgenerate

endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_overflow,
  input logic              out_inexact
);

  localparam logic [EXP_W-1:0] ONES = {EXP_W{1'b1}};
  localparam logic [WORD_W-2:0] MAG_INF  = {ONES, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-2:0] MAG_MAXF = {ONES - 1'b1, {FRAC_W{1'b1}}};

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  assign exp_f  = out_word[WORD_W-2:FRAC_W];
  assign frac_f = out_word[FRAC_W-1:0];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_overflow) && $stable(out_inexact)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact); // R8
  AST_INF_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && exp_f == ONES |-> out_overflow && frac_f == '0); // R5
  AST_OVF_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> (out_word[WORD_W-2:0] == MAG_INF || out_word[WORD_W-2:0] == MAG_MAXF)); // R6
  AST_TRUNC_NO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode != 2'b00 |=> exp_f != ONES); // R3
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && exp_f == '0 |-> frac_f == '0); // R7

endmodule

bind fp_round_unit fp_round_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [23:0] in_sig = '0;
  logic        in_guard = 1'b0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_overflow;
  logic        out_inexact;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  fp_round_unit u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_sign, .in_exp, .in_sig,
    .in_guard, .in_sticky, .in_mode, .out_valid, .out_ready,
    .out_word, .out_overflow, .out_inexact
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [33:0] ref_round(logic s, int e, logic [23:0] m,
                                            logic g, logic st, logic [1:0] md);
    int b;
    logic [24:0] t;
    logic up;
    b = e + 127;
    if (m == 24'd0) return {1'b0, g | st, s, 31'd0};
    if (b <= 0) return {1'b0, 1'b1, s, 31'd0};
    up = (md == 2'b00) && g && (st || m[0]);
    t = {1'b0, m} + {24'd0, up};
    if (t[24]) begin
      t = t >> 1;
      b = b + 1;
    end
    if (b >= 255) return {1'b1, 1'b1, s, (md == 2'b00) ? 31'h7F800000 : 31'h7F7FFFFF};
    return {1'b0, g | st, s, b[7:0], t[22:0]};
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual ovf=%0b inx=%0b word=%08h expected ovf=%0b inx=%0b word=%08h",
               tag, act[33], act[32], act[31:0], exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp_v);
    end
  endtask

  task automatic drive(logic s, int e, logic [23:0] m, logic g, logic st, logic [1:0] md);
    in_sign   = s;
    in_exp    = 10'(e);
    in_sig    = m;
    in_guard  = g;
    in_sticky = st;
    in_mode   = md;
    in_valid  = 1'b1;
  endtask

  task automatic run_one(string tag, logic s, int e, logic [23:0] m, logic g, logic st,
                         logic [1:0] md, logic [33:0] exp_v);
    @(negedge clk);
    drive(s, e, m, g, st, md);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check(tag, {out_overflow, out_inexact, out_word}, exp_v);
  endtask

  task automatic run_ref(string tag, logic s, int e, logic [23:0] m, logic g, logic st,
                         logic [1:0] md);
    run_one(tag, s, e, m, g, st, md, ref_round(s, e, m, g, st, md));
  endtask

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    check_bit("R11 out_valid after reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R11 out_valid idle", out_valid, 1'b0);
    check_bit("R11 in_ready idle", in_ready, 1'b1);

    // R1 nearest-even: tie even kept, tie odd up, above half up
    run_one("R1 tie even", 0, 0, 24'h800000, 1, 0, 2'b00, {2'b01, 32'h3F800000});
    run_one("R1 tie odd", 0, 0, 24'h800001, 1, 0, 2'b00, {2'b01, 32'h3F800002});
    run_one("R1 above half", 0, 0, 24'h800000, 1, 1, 2'b00, {2'b01, 32'h3F800001});
    run_one("R1 below half", 1, 3, 24'h800003, 0, 1, 2'b00, {2'b01, 32'hC1000003});
    // R2 truncation
    run_one("R2 truncate", 0, 0, 24'h800001, 1, 1, 2'b01, {2'b01, 32'h3F800001});
    // R3 spare codes behave as truncation
    run_one("R3 code 10", 0, 0, 24'h800001, 1, 1, 2'b10, {2'b01, 32'h3F800001});
    run_one("R3 code 11", 1, 0, 24'hFFFFFF, 1, 1, 2'b11, {2'b01, 32'hBFFFFFFF});
    // R4 carry out renormalizes
    run_one("R4 carry", 0, 0, 24'hFFFFFF, 1, 0, 2'b00, {2'b01, 32'h40000000});
    // R5 nearest overflow threshold
    run_one("R5 inf pos", 0, 127, 24'hFFFFFF, 1, 0, 2'b00, {2'b11, 32'h7F800000});
    run_one("R5 inf neg", 1, 127, 24'hFFFFFF, 1, 0, 2'b00, {2'b11, 32'hFF800000});
    run_one("R5 below threshold", 0, 127, 24'hFFFFFF, 0, 1, 2'b00, {2'b01, 32'h7F7FFFFF});
    run_one("R5 exp 128", 0, 128, 24'h800000, 0, 0, 2'b00, {2'b11, 32'h7F800000});
    // R6 truncation saturates
    run_one("R6 sat pos", 0, 128, 24'h800000, 0, 0, 2'b01, {2'b11, 32'h7F7FFFFF});
    run_one("R6 sat neg", 1, 200, 24'h900000, 0, 0, 2'b01, {2'b11, 32'hFF7FFFFF});
    run_one("R6 no carry at top", 0, 127, 24'hFFFFFF, 1, 0, 2'b01, {2'b01, 32'h7F7FFFFF});
    // R7 flush below normal
    run_one("R7 flush pos", 0, -127, 24'h800000, 0, 0, 2'b00, {2'b01, 32'h00000000});
    run_one("R7 flush neg", 1, -200, 24'hFFFFFF, 1, 1, 2'b00, {2'b01, 32'h80000000});
    run_one("R7 min normal", 0, -126, 24'h800000, 0, 0, 2'b00, {2'b00, 32'h00800000});
    // R8 exact result
    run_one("R8 exact", 0, 0, 24'h800000, 0, 0, 2'b00, {2'b00, 32'h3F800000});
    run_one("R8 sticky only", 0, 1, 24'hC00000, 0, 1, 2'b01, {2'b01, 32'h40400000});
    // R9 zero significand
    run_one("R9 neg zero", 1, 50, 24'h000000, 0, 0, 2'b00, {2'b00, 32'h80000000});
    run_one("R9 zero lossy", 0, 0, 24'h000000, 1, 0, 2'b01, {2'b01, 32'h00000000});

    // R10 stall, hold, and drain plus accept on one edge
    @(negedge clk);
    out_ready = 1'b0;
    drive(0, 0, 24'hA00000, 0, 0, 2'b00);
    @(negedge clk);
    drive(1, 1, 24'h800000, 0, 0, 2'b00);
    check_bit("R10 stalled valid", out_valid, 1'b1);
    check_bit("R10 stalled in_ready", in_ready, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 hold", {out_overflow, out_inexact, out_word}, {2'b00, 32'h3FA00000});
    check_bit("R10 still blocked", in_ready, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10 next valid", out_valid, 1'b1);
    check("R10 next word", {out_overflow, out_inexact, out_word}, {2'b00, 32'hC0000000});
    @(negedge clk);
    check_bit("R10 drained", out_valid, 1'b0);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 random mix against bench model
    for (int i = 0; i < 400; i++) begin
      logic [23:0] m;
      int e;
      m = {1'b1, 23'($urandom)};
      if (($urandom & 15) == 0) m = 24'd0;
      if (($urandom & 7) == 0) m = 24'hFFFFFF;
      e = int'($urandom_range(0, 300)) - 150;
      run_ref("R1-mix random", 1'($urandom), e, m, 1'($urandom), 1'($urandom), 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule